// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the privileged control registers of a processor core: translation staging registers (slot index, two low page entries, table context, page size mask, locked-entry count, high page entry with address-space tag), the processor status and exception cause words, exception return addresses, a debug control word, a cache tag staging word and a scratch word. Software reaches them through a write port and a combinational read port, each addressed by a 5-bit register number and a 3-bit select. Every register applies its own writable-bit mask, and some fields are owned by hardware and survive software writes.

Four mode flags are kept outside the stored status and debug words: user mode, exception level, error level and debug mode. They are driven out as ports and merged into the read value. The pending hardware interrupt lines are copied each cycle into the cause word. A two-state machine drives the interrupt request. Its states are IRQ_IDLE and IRQ_ACTIVE. The transition RAISE (IRQ_IDLE to IRQ_ACTIVE) is taken when a status write turns the enable bit on while no blocking mode is set and an unmasked interrupt is pending. The transition DROP (IRQ_ACTIVE to IRQ_IDLE) is taken when a status write turns the enable bit off. In every other case the state holds.

A write to the high page entry that changes its 8-bit address-space tag produces a one-cycle pulse, so that translation caches elsewhere can be flushed.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset every register reads 0x00000000, and irq_req, asid_chg and all four mode flags are low.
- R2: Every implemented register uses select 0. An access with a nonzero select hits no register: a write changes nothing, and a read returns zero. For example, writing register 14 with select 2 leaves register 14 unchanged.
- R3: Register 0 (slot index) keeps its bit 31 across writes and takes only bits 3:0 from the written data. Writing 0xFFFFFFFF after reset reads back 0x0000000F.
- R4: Register 4 (context) keeps bits 31:24, takes bits 23:4 from the data, and always reads bits 3:0 as zero. Writing 0xFFFFFFFF after reset reads back 0x00FFFFF0.
- R5: Plain masked writes store data AND mask. Register 5 uses 0x01FFE000, register 6 uses 0x0000000F, register 10 uses 0xFFFFF0FF, registers 2 and 3 use 0x3FFFFFFF, and register 28 select 0 uses 0xFFFFFCF6. Registers 14, 24, 30 and 31 store all 32 bits.
- R6: Register 12 (status) stores data AND 0xFA78FF01. In the same write, data bit 4 sets mode_user, bit 2 sets mode_erl and bit 1 sets mode_exl. A read of register 12 ORs those flags back into bits 4, 2 and 1.
- R7: A status write causes RAISE only when all of these hold: the new bit 0 (IE) is 1, the stored IE was 0, the new bits 1 and 2 are 0, mode_dbg is 0, and (new status AND cause AND 0x0000FF00) is nonzero. irq_req then goes high after that clock edge.
- R8: A status write with data bit 0 = 0, while the stored IE is 1, causes DROP. irq_req is low after that edge.
- R9: Register 13 (cause) takes only bits 9:8 from a write and keeps bits 31, 29:28, 15:11 and 6:2. Bits 15:10 are loaded every cycle from hw_irq[5:0], with one cycle of delay.
- R10: Register 23 (debug) keeps the bits in 0x8C03FC1F and takes the bits in 0x13300120 from the data. Data bit 30 sets mode_dbg, and a read ORs mode_dbg into bit 30.
- R11: A write to register 10 whose data bits 7:0 differ from the stored bits 7:0 makes asid_chg high for exactly the following cycle. A write with the same tag gives no pulse.
- R12: Register numbers without storage (1, 7, 8, 9, 11, 15-22, 25-27, 29, and 28 with a nonzero select) read zero, and writes to them are ignored.
- R13: irq_req changes only in the cycle after a status write. Other writes, such as one to the cause word, leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_reg | input | 5 | Write register number |
| wr_sel | input | 3 | Write select |
| wr_data | input | 32 | Write data |
| rd_reg | input | 5 | Read register number |
| rd_sel | input | 3 | Read select |
| rd_data | output | 32 | Combinational read data |
| hw_irq | input | 6 | Pending hardware interrupt lines |
| irq_req | output | 1 | Interrupt request |
| mode_user | output | 1 | User mode flag |
| mode_exl | output | 1 | Exception level flag |
| mode_erl | output | 1 | Error level flag |
| mode_dbg | output | 1 | Debug mode flag |
| asid_chg | output | 1 | One-cycle pulse on an address-space tag change |

## Verification
The assertions assume two things about the inputs. First, wr_en, wr_reg, wr_sel and wr_data are stable around each rising edge. Second, hw_irq is held at zero while reset is active, because the cause-update check compares against the value of hw_irq one cycle earlier. The bench meets both conditions by changing every input only on falling edges and by leaving hw_irq at zero until reset has been released. The interrupt tests place each pending source and each blocking flag in a known state before the status write under test.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int REG_W   = 5;
    localparam int SEL_W   = 3;
    localparam int XLEN    = 32;
    localparam int HWIRQ_N = 6;
    localparam int HWIRQ_LO = 10;
    localparam int ASID_W  = 8;

    // storage slots
    localparam int SL_INDEX = 0;
    localparam int SL_ELO0  = 1;
    localparam int SL_ELO1  = 2;
    localparam int SL_CTX   = 3;
    localparam int SL_PMASK = 4;
    localparam int SL_WIRED = 5;
    localparam int SL_EHI   = 6;
    localparam int SL_STAT  = 7;
    localparam int SL_CAUSE = 8;
    localparam int SL_EPC   = 9;
    localparam int SL_DBG   = 10;
    localparam int SL_DEPC  = 11;
    localparam int SL_TAG   = 12;
    localparam int SL_EEPC  = 13;
    localparam int SL_SAVE  = 14;
    localparam int SLOT_N   = 15;

    // status / debug bit positions
    localparam int ST_IE  = 0;
    localparam int ST_EXL = 1;
    localparam int ST_ERL = 2;
    localparam int ST_UM  = 4;
    localparam int DB_DM  = 30;

    localparam logic [XLEN-1:0] IRQ_MASK_FIELD = 32'h0000_FF00;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_ACTIVE
    } irq_state_e;

    function automatic logic [REG_W-1:0] slot_reg(input int s);
        case (s)
            SL_INDEX: return 5'd0;
            SL_ELO0:  return 5'd2;
            SL_ELO1:  return 5'd3;
            SL_CTX:   return 5'd4;
            SL_PMASK: return 5'd5;
            SL_WIRED: return 5'd6;
            SL_EHI:   return 5'd10;
            SL_STAT:  return 5'd12;
            SL_CAUSE: return 5'd13;
            SL_EPC:   return 5'd14;
            SL_DBG:   return 5'd23;
            SL_DEPC:  return 5'd24;
            SL_TAG:   return 5'd28;
            SL_EEPC:  return 5'd30;
            default:  return 5'd31;
        endcase
    endfunction

    // bits taken from written data
    function automatic logic [XLEN-1:0] slot_wmask(input int s);
        case (s)
            SL_INDEX: return 32'h0000_000F;
            SL_ELO0:  return 32'h3FFF_FFFF;
            SL_ELO1:  return 32'h3FFF_FFFF;
            SL_CTX:   return 32'h00FF_FFF0;
            SL_PMASK: return 32'h01FF_E000;
            SL_WIRED: return 32'h0000_000F;
            SL_EHI:   return 32'hFFFF_F0FF;
            SL_STAT:  return 32'hFA78_FF01;
            SL_CAUSE: return 32'h0000_0300;
            SL_DBG:   return 32'h1330_0120;
            SL_TAG:   return 32'hFFFF_FCF6;
            default:  return 32'hFFFF_FFFF;
        endcase
    endfunction

    // bits owned by hardware, kept across writes
    function automatic logic [XLEN-1:0] slot_kmask(input int s);
        case (s)
            SL_INDEX: return 32'h8000_0000;
            SL_CTX:   return 32'hFF00_0000;
            SL_CAUSE: return 32'hB000_F87C;
            SL_DBG:   return 32'h8C03_FC1F;
            default:  return 32'h0000_0000;
        endcase
    endfunction
endpackage

// File: rtl/sysctl_addr_decode.sv
module sysctl_addr_decode
    import sysctl_pkg::*;
(
    input  logic             en,
    input  logic [REG_W-1:0] reg_no,
    input  logic [SEL_W-1:0] sel_no,
    output logic [SLOT_N-1:0] hit
);
    // every implemented slot lives at select 0
    always_comb begin
        hit = '0;
        if (en && sel_no == '0) begin
            for (int s = 0; s < SLOT_N; s++) begin
                if (reg_no == slot_reg(s)) hit[s] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sysctl_irq_fsm.sv
module sysctl_irq_fsm
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stat_wr,
    input  logic old_ie,
    input  logic new_ie,
    input  logic new_exl,
    input  logic new_erl,
    input  logic dbg_mode,
    input  logic pending,
    output logic irq_req
);
    irq_state_e state_q, state_d;
    logic raise_ok, drop_ok;

    assign raise_ok = new_ie && !old_ie && !new_exl && !new_erl && !dbg_mode && pending;
    assign drop_ok  = !new_ie && old_ie;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (stat_wr && raise_ok) state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (stat_wr && drop_ok)  state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_req = (state_q == IRQ_ACTIVE);
    end

    a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && raise_ok) |=> irq_req);
    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && drop_ok) |=> !irq_req);
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> $stable(irq_req));
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_reg,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [XLEN-1:0]    wr_data,
    input  logic [REG_W-1:0]   rd_reg,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [XLEN-1:0]    rd_data,
    input  logic [HWIRQ_N-1:0] hw_irq,
    output logic               irq_req,
    output logic               mode_user,
    output logic               mode_exl,
    output logic               mode_erl,
    output logic               mode_dbg,
    output logic               asid_chg
);
    localparam int HWIRQ_HI = HWIRQ_LO + HWIRQ_N - 1;

    logic [SLOT_N-1:0] whit, rhit;
    logic [XLEN-1:0]   stored [SLOT_N];
    logic [XLEN-1:0]   view   [SLOT_N];
    logic              past_ok;

    sysctl_addr_decode u_wdec (
        .en(wr_en), .reg_no(wr_reg), .sel_no(wr_sel), .hit(whit)
    );
    sysctl_addr_decode u_rdec (
        .en(1'b1), .reg_no(rd_reg), .sel_no(rd_sel), .hit(rhit)
    );

    for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
        logic [XLEN-1:0] q;
        logic [XLEN-1:0] merged;
        assign merged = (q & slot_kmask(g)) | (wr_data & slot_wmask(g));
        if (g == SL_CAUSE) begin : g_cause
            logic [XLEN-1:0] nxt;
            always_comb begin
                nxt = whit[g] ? merged : q;
                nxt[HWIRQ_HI:HWIRQ_LO] = hw_irq;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= nxt;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       q <= '0;
                else if (whit[g]) q <= merged;
            end
        end
        assign stored[g] = q;
        if (g == SL_STAT) begin : g_vstat
            always_comb begin
                view[g] = q;
                view[g][ST_UM]  = q[ST_UM]  | mode_user;
                view[g][ST_ERL] = q[ST_ERL] | mode_erl;
                view[g][ST_EXL] = q[ST_EXL] | mode_exl;
            end
        end else if (g == SL_DBG) begin : g_vdbg
            always_comb begin
                view[g] = q;
                view[g][DB_DM] = q[DB_DM] | mode_dbg;
            end
        end else begin : g_vplain
            assign view[g] = q;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < SLOT_N; s++) begin
            if (rhit[s]) rd_data = rd_data | view[s];
        end
    end

    // mode flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_user <= 1'b0;
            mode_exl  <= 1'b0;
            mode_erl  <= 1'b0;
            mode_dbg  <= 1'b0;
        end else begin
            if (whit[SL_STAT]) begin
                mode_user <= wr_data[ST_UM];
                mode_exl  <= wr_data[ST_EXL];
                mode_erl  <= wr_data[ST_ERL];
            end
            if (whit[SL_DBG]) mode_dbg <= wr_data[DB_DM];
        end
    end

    // address-space tag change pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) asid_chg <= 1'b0;
        else        asid_chg <= whit[SL_EHI] &&
                                (wr_data[ASID_W-1:0] != stored[SL_EHI][ASID_W-1:0]);
    end

    logic [XLEN-1:0] new_status;
    assign new_status = wr_data & slot_wmask(SL_STAT);

    sysctl_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_wr  (whit[SL_STAT]),
        .old_ie   (stored[SL_STAT][ST_IE]),
        .new_ie   (wr_data[ST_IE]),
        .new_exl  (wr_data[ST_EXL]),
        .new_erl  (wr_data[ST_ERL]),
        .dbg_mode (mode_dbg),
        .pending  (|(new_status & stored[SL_CAUSE] & IRQ_MASK_FIELD)),
        .irq_req  (irq_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r2_nonzero_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != '0) |=> $stable(stored[SL_EPC]));
    a_r6_mode_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0 && wr_reg == 5'd12) |=>
        (mode_user == $past(wr_data[ST_UM]) && mode_exl == $past(wr_data[ST_EXL])));
    a_r9_hw_lines: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |=> stored[SL_CAUSE][HWIRQ_HI:HWIRQ_LO] == $past(hw_irq));
    a_r10_dbg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0 && wr_reg == 5'd23) |=> mode_dbg == $past(wr_data[DB_DM]));
    a_r11_asid_src: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && asid_chg) |-> $past(wr_en && wr_reg == 5'd10 && wr_sel == '0));
endmodule

// File: tb/test_sysctl_regfile.sv
`timescale 1ns/1ps
module test_sysctl_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_reg = '0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_reg = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [5:0]  hw_irq = '0;
    logic        irq_req, mode_user, mode_exl, mode_erl, mode_dbg, asid_chg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sysctl_regfile i_sysctl_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_reg(rd_reg), .rd_sel(rd_sel), .rd_data(rd_data),
        .hw_irq(hw_irq), .irq_req(irq_req), .mode_user(mode_user), .mode_exl(mode_exl),
        .mode_erl(mode_erl), .mode_dbg(mode_dbg), .asid_chg(asid_chg)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] r, input logic [2:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_reg = r; wr_sel = s; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] r, input logic [2:0] s, output logic [31:0] d);
        rd_reg = r; rd_sel = s;
        #1;
        d = rd_data;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int r = 0; r < 32; r++) begin
            rd(5'(r), 3'd0, v);
            check("R1 reset read", v, 32'h0);
        end
        check("R1 reset outputs", {26'd0, irq_req, asid_chg, mode_user, mode_exl, mode_erl, mode_dbg}, 32'h0);
    endtask

    task automatic t_masks();
        logic [31:0] v;
        wr(5'd0, 3'd0, 32'hFFFF_FFFF); rd(5'd0, 3'd0, v); check("R3 index", v, 32'h0000_000F);
        wr(5'd4, 3'd0, 32'hFFFF_FFFF); rd(5'd4, 3'd0, v); check("R4 context", v, 32'h00FF_FFF0);
        wr(5'd5, 3'd0, 32'hFFFF_FFFF); rd(5'd5, 3'd0, v); check("R5 pagemask", v, 32'h01FF_E000);
        wr(5'd6, 3'd0, 32'hFFFF_FFFF); rd(5'd6, 3'd0, v); check("R5 wired", v, 32'h0000_000F);
        wr(5'd2, 3'd0, 32'hFFFF_FFFF); rd(5'd2, 3'd0, v); check("R5 lo0", v, 32'h3FFF_FFFF);
        wr(5'd3, 3'd0, 32'hC000_0005); rd(5'd3, 3'd0, v); check("R5 lo1", v, 32'h0000_0005);
        wr(5'd28, 3'd0, 32'hFFFF_FFFF); rd(5'd28, 3'd0, v); check("R5 tag", v, 32'hFFFF_FCF6);
        wr(5'd24, 3'd0, 32'hA5A5_5A5A); rd(5'd24, 3'd0, v); check("R5 depc", v, 32'hA5A5_5A5A);
        wr(5'd30, 3'd0, 32'h1234_5678); rd(5'd30, 3'd0, v); check("R5 errepc", v, 32'h1234_5678);
        wr(5'd31, 3'd0, 32'hFFFF_0000); rd(5'd31, 3'd0, v); check("R5 save", v, 32'hFFFF_0000);
    endtask

    task automatic t_select_and_unimpl();
        logic [31:0] v;
        wr(5'd14, 3'd0, 32'h1111_2222);
        wr(5'd14, 3'd2, 32'hDEAD_BEEF);
        rd(5'd14, 3'd0, v); check("R2 sel write ignored", v, 32'h1111_2222);
        rd(5'd14, 3'd1, v); check("R2 sel read zero", v, 32'h0);
        wr(5'd7, 3'd0, 32'hFFFF_FFFF);
        rd(5'd7, 3'd0, v); check("R12 reg7", v, 32'h0);
        wr(5'd28, 3'd1, 32'h0000_0000);
        rd(5'd28, 3'd0, v); check("R12 tag sel1 write ignored", v, 32'hFFFF_FCF6);
        rd(5'd28, 3'd1, v); check("R12 tag sel1 read", v, 32'h0);
        rd(5'd16, 3'd0, v); check("R12 reg16", v, 32'h0);
    endtask

    task automatic t_status_debug();
        logic [31:0] v;
        wr(5'd12, 3'd0, 32'hFFFF_FFFE);
        rd(5'd12, 3'd0, v); check("R6 status read", v, 32'hFA78_FF16);
        check("R6 flags", {29'd0, mode_user, mode_erl, mode_exl}, 32'h7);
        wr(5'd12, 3'd0, 32'h0000_0000);
        rd(5'd12, 3'd0, v); check("R6 status cleared", v, 32'h0);
        wr(5'd23, 3'd0, 32'hFFFF_FFFF);
        rd(5'd23, 3'd0, v); check("R10 debug read", v, 32'h5330_0120);
        check("R10 dm flag", {31'd0, mode_dbg}, 32'h1);
        wr(5'd23, 3'd0, 32'h0);
        rd(5'd23, 3'd0, v); check("R10 debug cleared", v, 32'h0);
    endtask

    task automatic t_cause();
        logic [31:0] v;
        wr(5'd13, 3'd0, 32'hFFFF_FFFF);
        rd(5'd13, 3'd0, v); check("R9 cause sw bits", v, 32'h0000_0300);
        hw_irq = 6'b100001;
        rd(5'd13, 3'd0, v); check("R9 cause not yet", v, 32'h0000_0300);
        tick();
        rd(5'd13, 3'd0, v); check("R9 cause hw bits", v, 32'h0000_8700);
        hw_irq = 6'd0;
        wr(5'd13, 3'd0, 32'h0);
        rd(5'd13, 3'd0, v); check("R9 cause cleared", v, 32'h0);
    endtask

    task automatic t_asid();
        logic [31:0] v;
        wr(5'd10, 3'd0, 32'h1234_5601);
        check("R11 pulse on change", {31'd0, asid_chg}, 32'h1);
        rd(5'd10, 3'd0, v); check("R5 entryhi", v, 32'h1234_5001);
        tick();
        check("R11 single cycle", {31'd0, asid_chg}, 32'h0);
        wr(5'd10, 3'd0, 32'hABCD_E001);
        check("R11 no pulse same tag", {31'd0, asid_chg}, 32'h0);
    endtask

    task automatic t_irq_raise_drop();
        hw_irq = 6'b000001;
        tick();
        wr(5'd12, 3'd0, 32'h0000_0401);
        check("R7 raise", {31'd0, irq_req}, 32'h1);
        wr(5'd14, 3'd0, 32'h0);
        check("R13 hold on other write", {31'd0, irq_req}, 32'h1);
        hw_irq = 6'd0;
        tick();
        check("R13 hold on line drop", {31'd0, irq_req}, 32'h1);
        wr(5'd12, 3'd0, 32'h0000_0400);
        check("R8 drop", {31'd0, irq_req}, 32'h0);
    endtask

    task automatic t_irq_blocked();
        hw_irq = 6'b000001;
        tick();
        wr(5'd12, 3'd0, 32'h0000_0403);
        check("R7 blocked by exl", {31'd0, irq_req}, 32'h0);
        wr(5'd12, 3'd0, 32'h0000_0400);
        wr(5'd12, 3'd0, 32'h0000_0405);
        check("R7 blocked by erl", {31'd0, irq_req}, 32'h0);
        wr(5'd12, 3'd0, 32'h0000_0400);
        wr(5'd23, 3'd0, 32'h4000_0000);
        wr(5'd12, 3'd0, 32'h0000_0401);
        check("R7 blocked by debug", {31'd0, irq_req}, 32'h0);
        wr(5'd23, 3'd0, 32'h0);
        wr(5'd12, 3'd0, 32'h0000_0400);
        wr(5'd12, 3'd0, 32'h0000_0801);
        check("R7 blocked by mask", {31'd0, irq_req}, 32'h0);
        wr(5'd12, 3'd0, 32'h0);
        hw_irq = 6'd0;
        tick();
    endtask

    task automatic t_irq_soft();
        wr(5'd13, 3'd0, 32'h0000_0100);
        wr(5'd12, 3'd0, 32'h0000_0101);
        check("R7 software raise", {31'd0, irq_req}, 32'h1);
        wr(5'd13, 3'd0, 32'h0);
        check("R13 hold on cause write", {31'd0, irq_req}, 32'h1);
        wr(5'd12, 3'd0, 32'h0000_0100);
        check("R8 software drop", {31'd0, irq_req}, 32'h0);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_select_and_unimpl();
        t_status_debug();
        t_cause();
        t_asid();
        t_irq_raise_drop();
        t_irq_blocked();
        t_irq_soft();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end
endmodule